// File: doc/BRIEF.md
# Carrier Sense Loss Monitor

This block sits beside a half-duplex Ethernet MAC and checks, for every frame sent toward the PHY, that the PHY reports carrier soon after the transmit-active signal goes high. A timer is loaded on the rising edge of transmit-active. It counts one slot time, with the length picked from the link speed sampled at that edge. A per-frame flag records whether carrier was seen inside that window.

When the MAC later strobes that the frame finished successfully, the block counts the frame if carrier never showed up in the window. This happens only while transmission is allowed, the link is half duplex and the link is not in serial (SerDes) mode. A rise in this count points to a failed link or a misconfigured PHY.

The count is a saturating register that software reads through a read-clear strobe. The value on the output during the read cycle is the value read. The register clears on the following edge, and an event that lands in the same cycle is kept.

Top module: `carrier_loss_monitor`

## Requirements
- R1: After synchronous active-low reset the count output is zero.
- R2: The carrier window covers the clock samples from the one where transmit-active first reads high (sample 0) through sample SLOT-1. Carrier high in any of those samples, including sample 0 and sample SLOT-1, keeps the frame from being counted. Carrier first seen at sample SLOT or later does not.
- R3: SLOT is chosen from the speed code at the transmit-active rising edge: code 2'b00 (10 Mb/s) gives SLOT_10M (default 128), 2'b01 (100 Mb/s) gives SLOT_100M (default 128), and 2'b10 or 2'b11 (1 Gb/s) give SLOT_1G (default 512).
- R4: A frame is counted only on a success strobe. The count rises by exactly one on the edge after the strobe cycle. A frame that ends without a strobe is not counted.
- R5: No frame is counted while the transmit-allow input is low in the strobe cycle.
- R6: No frame is counted while the half-duplex input is low (full duplex) in the strobe cycle.
- R7: No frame is counted while the serial-link-mode input is high in the strobe cycle.
- R8: A read-clear strobe leaves the current value on the output in that cycle, and the count is zero on the next cycle. If a counted frame is judged in the same cycle as the read, the next value is one.
- R9: The count saturates at all ones (2^CNT_W-1) and stays there until read.
- R10: A success strobe with no transmit-active rising edge since the previous strobe is not counted.
- R11: The carrier flag is reset at each transmit-active rising edge, so carrier seen during one frame never excuses the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_active_i | input | 1 | MAC is driving a frame toward the PHY |
| carrier_i | input | 1 | Carrier sense reported by the PHY |
| frame_done_i | input | 1 | One-cycle strobe: frame completed successfully |
| link_speed_i | input | 2 | 00 = 10 Mb/s, 01 = 100 Mb/s, 1x = 1 Gb/s |
| half_duplex_i | input | 1 | 1 = half duplex |
| serdes_link_i | input | 1 | 1 = serial link mode, counting disabled |
| tx_allow_i | input | 1 | Transmission enabled |
| read_clear_i | input | 1 | Read strobe; count clears on the next edge |
| lost_count_o | output | CNT_W | Frames sent without carrier in time |

## Verification
The bench puts carrier at the first and last samples inside the window and at the first sample past it, at both slot lengths, and uses the alternate 1 Gb/s code. A timer that is off by one counts or misses a frame at those edges.

Frames that fail one gating condition at a time must leave the count alone. So must a stray strobe with no transmission behind it, and a frame whose carrier came in an earlier frame. A design that judged at the wrong time, or kept a stale flag, would count them.

A read that coincides with a counted frame must leave one, not zero. A narrow 4-bit copy is driven past its limit to show that it holds at all ones and does not wrap.

// File: rtl/carrier_loss_pkg.sv
// Shared types for the carrier sense loss monitor.
// Assumes the MAC presents its speed as a two-bit code.
package carrier_loss_pkg;

    typedef enum logic [1:0] {
        SPD_10M    = 2'b00,
        SPD_100M   = 2'b01,
        SPD_1G     = 2'b10,
        SPD_1G_ALT = 2'b11
    } link_speed_e;

endpackage

// File: rtl/carrier_loss_tx_start.sv
// Detects the rising edge of transmit-active and keeps an "armed" flag.
// The flag is set by each new transmission and cleared by the success strobe
// that judges it. Assumes tx_active_i is synchronous to clk.
module carrier_loss_tx_start (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active_i,
    input  logic frame_done_i,
    output logic start_o,
    output logic armed_o
);

    logic tx_prev_q;
    logic armed_q;

    // Register the previous transmit-active sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_prev_q <= 1'b0;
        else        tx_prev_q <= tx_active_i;
    end

    assign start_o = tx_active_i && !tx_prev_q;

    // Arm on a new transmission, disarm once a strobe has judged it.
    always_ff @(posedge clk) begin
        if (!rst_n)            armed_q <= 1'b0;
        else if (start_o)      armed_q <= 1'b1;
        else if (frame_done_i) armed_q <= 1'b0;
    end

    assign armed_o = armed_q;

    assert_arm_on_start_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> armed_q);
    assert_disarm_on_done_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && !start_o) |=> !armed_q);

endmodule

// File: rtl/carrier_loss_slot_timer.sv
// Slot-time window timer. Loaded on the transmit start with the slot length
// for the speed sampled at that edge, then counts down to zero.
// The window is open in the start cycle and while the count is non-zero,
// so it spans exactly SLOT samples. Assumes every SLOT_* is at least 1.
module carrier_loss_slot_timer
    import carrier_loss_pkg::*;
#(
    parameter int unsigned SLOT_10M  = 128,
    parameter int unsigned SLOT_100M = 128,
    parameter int unsigned SLOT_1G   = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] speed_i,
    output logic       window_o
);

    localparam int unsigned MAX_A    = (SLOT_10M > SLOT_100M) ? SLOT_10M : SLOT_100M;
    localparam int unsigned MAX_SLOT = (MAX_A > SLOT_1G) ? MAX_A : SLOT_1G;
    localparam int unsigned REM_W    = (MAX_SLOT > 1) ? $clog2(MAX_SLOT) : 1;

    localparam logic [REM_W-1:0] LOAD_10M  = REM_W'(SLOT_10M - 1);
    localparam logic [REM_W-1:0] LOAD_100M = REM_W'(SLOT_100M - 1);
    localparam logic [REM_W-1:0] LOAD_1G   = REM_W'(SLOT_1G - 1);

    logic [REM_W-1:0] remain_q;
    logic [REM_W-1:0] load_val;
    link_speed_e      speed;

    assign speed = link_speed_e'(speed_i);

    // Pick the reload value for the current speed code.
    always_comb begin
        case (speed)
            SPD_10M:  load_val = LOAD_10M;
            SPD_100M: load_val = LOAD_100M;
            default:  load_val = LOAD_1G;
        endcase
    end

    // Load on start, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)               remain_q <= '0;
        else if (start_i)         remain_q <= load_val;
        else if (remain_q != '0)  remain_q <= remain_q - REM_W'(1);
    end

    assign window_o = start_i || (remain_q != '0);

    assert_countdown_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && remain_q != '0) |=> (remain_q == $past(remain_q) - REM_W'(1)));
    assert_idle_stays_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && remain_q == '0) |=> (remain_q == '0));
    assert_bounded_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        remain_q <= REM_W'(MAX_SLOT - 1));

endmodule

// File: rtl/carrier_loss_flag.sv
// Per-frame "carrier seen" flag. On transmit start it takes the current
// carrier sample. Afterwards it becomes sticky-high if carrier is high while
// the window is open. carrier_ok_o also covers a carrier sample in the
// judging cycle itself.
module carrier_loss_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic window_i,
    input  logic carrier_i,
    output logic carrier_ok_o
);

    logic seen_q;

    // Restart the flag per frame and record carrier inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                     seen_q <= 1'b0;
        else if (start_i)               seen_q <= carrier_i;
        else if (window_i && carrier_i) seen_q <= 1'b1;
    end

    assign carrier_ok_o = seen_q || (window_i && carrier_i);

    assert_fresh_frame_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !carrier_i) |=> !seen_q);
    assert_sticky_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !start_i) |=> seen_q);
    assert_no_late_set_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && !window_i && !start_i) |=> !seen_q);

endmodule

// File: rtl/carrier_loss_counter.sv
// Saturating event counter with read-clear. The output holds the current
// value; a clear strobe zeroes it on the next edge, and a bump arriving in
// the same cycle leaves a value of one.
module carrier_loss_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    // Next value: clear wins over holding, a bump stops at all ones.
    always_comb begin
        if (clear_i)                          count_d = bump_i ? CNT_ONE : '0;
        else if (bump_i && count_q != CNT_MAX) count_d = count_q + CNT_ONE;
        else                                  count_d = count_q;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;

    assert_reset_value_R1 : assert property (@(posedge clk)
        !rst_n |=> (count_q == '0));
    assert_clear_on_read_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !bump_i) |=> (count_q == '0));
    assert_clear_with_event_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && bump_i) |=> (count_q == CNT_ONE));
    assert_step_one_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (bump_i && !clear_i && count_q != CNT_MAX) |=> (count_q == $past(count_q) + CNT_ONE));
    assert_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (!bump_i && !clear_i) |=> $stable(count_q));
    assert_no_overflow_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX && !clear_i) |=> (count_q == CNT_MAX));

endmodule

// File: rtl/carrier_loss_monitor.sv
// Carrier sense loss monitor, top level. Judges each successfully completed
// half-duplex frame and counts it when carrier was not seen within one slot
// time of the transmit start. Counting is gated by transmit-allow, half
// duplex and not serial link mode, all sampled in the strobe cycle.
// Assumes the success strobe is a single-cycle pulse that follows the
// transmit start of the frame it reports.
module carrier_loss_monitor #(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned SLOT_10M  = 128,
    parameter int unsigned SLOT_100M = 128,
    parameter int unsigned SLOT_1G   = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_active_i,
    input  logic             carrier_i,
    input  logic             frame_done_i,
    input  logic [1:0]       link_speed_i,
    input  logic             half_duplex_i,
    input  logic             serdes_link_i,
    input  logic             tx_allow_i,
    input  logic             read_clear_i,
    output logic [CNT_W-1:0] lost_count_o
);

    logic start;
    logic armed;
    logic window;
    logic carrier_ok;
    logic mode_ok;
    logic bump;

    carrier_loss_tx_start u_tx_start (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_active_i  (tx_active_i),
        .frame_done_i (frame_done_i),
        .start_o      (start),
        .armed_o      (armed)
    );

    carrier_loss_slot_timer #(
        .SLOT_10M  (SLOT_10M),
        .SLOT_100M (SLOT_100M),
        .SLOT_1G   (SLOT_1G)
    ) u_slot_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .speed_i  (link_speed_i),
        .window_o (window)
    );

    carrier_loss_flag u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .window_i     (window),
        .carrier_i    (carrier_i),
        .carrier_ok_o (carrier_ok)
    );

    // Operating mode in which loss of carrier is meaningful.
    always_comb mode_ok = tx_allow_i && half_duplex_i && !serdes_link_i;

    // Judge the frame on its success strobe.
    always_comb bump = frame_done_i && armed && !carrier_ok && mode_ok;

    carrier_loss_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .bump_i  (bump),
        .clear_i (read_clear_i),
        .count_o (lost_count_o)
    );

    assert_gated_mode_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        bump |-> (half_duplex_i && !serdes_link_i && tx_allow_i));
    assert_needs_start_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        bump |-> (armed && frame_done_i));

endmodule

// File: tb/test_carrier_loss_monitor.sv
// Scoreboard bench: driver tasks model the expected count and push it per
// read; a monitor pops and compares when a read strobe is seen.
module test_carrier_loss_monitor;

    localparam int unsigned S10  = 128;
    localparam int unsigned S100 = 128;
    localparam int unsigned S1G  = 512;
    localparam int unsigned NMAX = 15;

    typedef struct {
        int unsigned wide;
        int unsigned narrow;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_active = 1'b0;
    logic        carrier = 1'b0;
    logic        done = 1'b0;
    logic [1:0]  speed = 2'b00;
    logic        half = 1'b1;
    logic        serdes = 1'b0;
    logic        allow = 1'b1;
    logic        rd = 1'b0;
    logic [31:0] cnt_wide;
    logic [3:0]  cnt_narrow;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned exp_w = 0;
    int unsigned exp_n = 0;
    bit          finished = 1'b0;
    item_t       sb_q[$];

    always #2 clk = ~clk;

    carrier_loss_monitor i_carrier_loss_monitor (
        .clk (clk), .rst_n (rst_n), .tx_active_i (tx_active), .carrier_i (carrier),
        .frame_done_i (done), .link_speed_i (speed), .half_duplex_i (half),
        .serdes_link_i (serdes), .tx_allow_i (allow), .read_clear_i (rd),
        .lost_count_o (cnt_wide)
    );

    carrier_loss_monitor #(.CNT_W (4)) i_carrier_loss_monitor_narrow (
        .clk (clk), .rst_n (rst_n), .tx_active_i (tx_active), .carrier_i (carrier),
        .frame_done_i (done), .link_speed_i (speed), .half_duplex_i (half),
        .serdes_link_i (serdes), .tx_allow_i (allow), .read_clear_i (rd),
        .lost_count_o (cnt_narrow)
    );

    task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare the value on the output during each read cycle.
    always @(negedge clk) begin
        if (rst_n && rd) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "scoreboard-empty", cnt_wide, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(cnt_wide == it.wide, it.req, cnt_wide, it.wide);
                check(cnt_narrow == 4'(it.narrow), {it.req, "-narrow"}, cnt_narrow, it.narrow);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int unsigned slot_of(input logic [1:0] s);
        if (s == 2'b00) return S10;
        if (s == 2'b01) return S100;
        return S1G;
    endfunction

    // Model one counted event into the expected values.
    task automatic model_event(input bit counted, input bit with_read);
        if (with_read) begin
            exp_w = counted ? 1 : 0;
            exp_n = counted ? 1 : 0;
        end else if (counted) begin
            exp_w = exp_w + 1;
            if (exp_n < NMAX) exp_n = exp_n + 1;
        end
    endtask

    task automatic do_read(input string req);
        item_t it;
        it.wide = exp_w; it.narrow = exp_n; it.req = req;
        sb_q.push_back(it);
        step(); rd = 1'b1;
        step(); rd = 1'b0;
        exp_w = 0; exp_n = 0;
    endtask

    // Drive one frame: len samples of transmit-active, then the strobe cycle.
    // crs_at is the sample index (0 = rising-edge sample) with carrier high, -1 none.
    task automatic frame(input logic [1:0] spd, input int crs_at, input int len,
                         input bit ok, input bit hd, input bit ser, input bit en,
                         input bit rd_at_strobe, input string req);
        bit counted;
        item_t it;
        speed = spd; half = hd; serdes = ser; allow = en;
        for (int k = 0; k < len; k++) begin
            step();
            tx_active = 1'b1; carrier = (k == crs_at); done = 1'b0;
        end
        step();
        tx_active = 1'b0; carrier = (len == crs_at); done = ok;
        if (rd_at_strobe) begin
            it.wide = exp_w; it.narrow = exp_n; it.req = req;
            sb_q.push_back(it);
            rd = 1'b1;
        end
        step();
        done = 1'b0; carrier = 1'b0; rd = 1'b0;
        counted = ok && hd && !ser && en &&
                  !(crs_at >= 0 && crs_at < int'(slot_of(spd)));
        model_event(counted, rd_at_strobe);
        half = 1'b1; serdes = 1'b0; allow = 1'b1;
    endtask

    task automatic stray_strobe();
        step(); done = 1'b1;
        step(); done = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        check(cnt_wide == 0, "R1 during reset", cnt_wide, 0);
        rst_n = 1'b1;
        step();
        do_read("R1 reset value");

        frame(2'b00, -1, 4, 1, 1, 0, 1, 0, "R4");
        do_read("R4 one lost-carrier frame");
        frame(2'b00, 0, 4, 1, 1, 0, 1, 0, "R2");
        do_read("R2 carrier at sample 0");
        frame(2'b00, 127, 130, 1, 1, 0, 1, 0, "R2");
        frame(2'b00, 128, 130, 1, 1, 0, 1, 0, "R2");
        do_read("R2 10M window edges 127/128");
        frame(2'b10, 511, 514, 1, 1, 0, 1, 0, "R3");
        frame(2'b10, 512, 514, 1, 1, 0, 1, 0, "R3");
        frame(2'b11, 200, 204, 1, 1, 0, 1, 0, "R3");
        do_read("R3 1G window edges and alt code");
        frame(2'b01, 127, 130, 1, 1, 0, 1, 0, "R3");
        frame(2'b01, 128, 130, 1, 1, 0, 1, 0, "R3");
        do_read("R3 100M window edges");

        frame(2'b00, -1, 4, 0, 1, 0, 1, 0, "R4");
        do_read("R4 no strobe no count");
        frame(2'b00, -1, 4, 1, 1, 0, 0, 0, "R5");
        do_read("R5 transmit disabled");
        frame(2'b00, -1, 4, 1, 0, 0, 1, 0, "R6");
        do_read("R6 full duplex");
        frame(2'b10, -1, 4, 1, 1, 1, 1, 0, "R7");
        do_read("R7 serial link mode");

        frame(2'b00, -1, 4, 1, 1, 0, 1, 0, "R10");
        stray_strobe();
        do_read("R10 stray strobe ignored");
        frame(2'b00, 2, 4, 1, 1, 0, 1, 0, "R11");
        frame(2'b00, -1, 4, 1, 1, 0, 1, 0, "R11");
        do_read("R11 flag restarts per frame");

        for (int i = 0; i < 3; i++) frame(2'b01, -1, 4, 1, 1, 0, 1, 0, "R8");
        do_read("R8 read value");
        do_read("R8 cleared after read");
        frame(2'b00, -1, 4, 1, 1, 0, 1, 1, "R8 read with event");
        do_read("R8 event kept across read");

        for (int i = 0; i < 17; i++) frame(2'b00, -1, 3, 1, 1, 0, 1, 0, "R9");
        do_read("R9 narrow saturates");
        do_read("R9 cleared after saturation");

        repeat (4) step();
        if (sb_q.size() != 0) check(1'b0, "scoreboard-leftover", sb_q.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule